// File: doc/BRIEF.md
# Single-Wire Autobaud Debug Serial Port

This block is a half-duplex asynchronous serial port that shares one open-drain pin with a host, as a debug and programming channel. It never knows its bit rate in advance: after reset, or after any line error, it waits for the host to send the sync character 80h. It measures the low span of that character and divides it by eight to get the bit period in system clocks. It then receives and transmits 8-bit characters at that rate and passes them to and from a command engine over a simple byte stream.

The port watches the shared line for three faults. A break is the line held low for more than nine bit periods. A framing error is a received stop bit that samples low. A collision is the port releasing the line for a high bit while the line reads low. Each fault pulses an abort strobe to the command engine, drops the learned rate, and pulls the line low for four character times (forty bit periods). The port then waits for the line to go high and for a new sync character. A break from the host also raises a held-in-reset flag until the line returns high. That flag does not clear any debug-mode state held outside the port.

Top module: `dbg_wire_port`

## Requirements
- R1: After reset the port does not pull the line, tx_ready_o, rx_valid_o, abort_o and hold_rst_o are low, and no rate is learned.
- R2: While unlocked, a falling edge starts a measurement of clocks until the next rising edge. The bit period becomes that count divided by 8, and tx_ready_o rises once the port is idle with the line high.
- R3: A sync low span of fewer than 32 clocks (a bit period under 4) is rejected: abort_o pulses once, the port stays unlocked and the line is not pulled.
- R4: A character is 10 bits at the learned period: a low start bit, 8 data bits least significant first, and a high stop bit. Each bit is sampled at its middle. A good stop bit gives a one-cycle rx_valid_o pulse with the byte on rx_data_o.
- R5: tx_ready_o is high only when locked, idle and the line reads high. A byte taken with tx_valid_o high sends start, data LSB first and stop, one learned period each, with the pull-low output high for a 0 bit.
- R6: A received stop bit sampled low gives no rx_valid_o, pulses abort_o, clears the rate and starts the echo break. It does not raise hold_rst_o.
- R7: A transmitted high bit that reads low on its last clock is a collision: abort_o pulses, the rate is cleared and the echo break starts.
- R8: While locked, the line low for more than nine full learned periods from its falling edge is a break. abort_o pulses, hold_rst_o rises and stays high until the line reads high, and the echo break starts. A low span of exactly nine periods followed by high is the ordinary character 00h.
- R9: The echo break pulls the line low for exactly 40 learned bit periods and then releases it. The port waits for the line to read high before it waits for a sync character.
- R10: After any abort, tx_ready_o stays low until a new sync character is measured, and the new rate replaces the old one.
- R11: While unlocked, a low span longer than 9*2^P_W clocks is a break. abort_o pulses and hold_rst_o is high until the line reads high, with no echo break.
- R12: tx_valid_i has no effect while no rate is learned: the line is not pulled and tx_ready_o stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_i | input | 1 | Level read from the shared open-drain pin |
| pull_low_o | output | 1 | High pulls the shared pin low |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit request |
| tx_ready_o | output | 1 | Port will take tx_data_i this cycle |
| abort_o | output | 1 | One-cycle strobe to abort the current command |
| hold_rst_o | output | 1 | Host break seen and line not yet high |

## Verification
The bench builds the port with P_W = 6. This brings the unlocked break limit down to 576 clocks, so the unlocked break and the rejected short sync run in a few hundred cycles. Every learned period from the minimum of 4 up to 12 clocks is swept. At each period the bench checks reception, transmission, the exact nine-period low character and a host break with its 40-period echo. At a period of 8 all 256 byte values are received and transmitted. The expected bit patterns and echo lengths are computed arithmetically from the period.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

    typedef enum logic [2:0] {
        ST_UNLOCK,
        ST_MEASURE,
        ST_IDLE,
        ST_RX,
        ST_TX,
        ST_ECHO,
        ST_RELEASE
    } dwp_state_e;

    localparam int FRAME_BITS    = 10;
    localparam int SYNC_SHIFT    = 3;   // sync low span is 8 bit times
    localparam int MIN_SYNC_CLKS = 32;  // bit period of at least 4 clocks
    localparam int BREAK_BITS    = 9;
    localparam int ECHO_BITS     = 40;  // four characters of ten bits
    localparam int IDX_W         = 6;

endpackage

// File: rtl/dwp_line_in.sv
module dwp_line_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    output logic line_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } line_s;

    line_s q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[STAGES-2:0], pad_i};
        d.prev = q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.sh[STAGES-1];
    assign fall_o = q.prev & ~q.sh[STAGES-1];

endmodule

// File: rtl/dwp_brk_det.sv
module dwp_brk_det #(
    parameter int P_W       = 12,
    parameter int CNT_W     = 16,
    parameter int UNLK_CLKS = 36864
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             line_i,
    input  logic             locked_i,
    input  logic [P_W-1:0]   period_i,
    output logic             brk_o
);

    localparam logic [CNT_W-1:0] UNLK_C = CNT_W'(UNLK_CLKS);

    typedef struct packed {
        logic [CNT_W-1:0] low;
    } det_s;

    det_s q, d;
    logic [CNT_W-1:0] per_ext;
    logic [CNT_W-1:0] thr;

    always_comb begin
        per_ext = {{(CNT_W-P_W){1'b0}}, period_i};
        thr     = locked_i ? ((per_ext << 3) + per_ext) : UNLK_C;
        d       = q;
        if (!en_i || line_i) begin
            d.low = '0;
        end else if (q.low != '1) begin
            d.low = q.low + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign brk_o = en_i & ~line_i & (q.low >= thr);

endmodule

// File: rtl/dwp_engine.sv
module dwp_engine
    import dwp_pkg::*;
#(
    parameter int P_W   = 12,
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_i,
    input  logic           fall_i,
    input  logic           brk_i,
    input  logic [7:0]     tx_data_i,
    input  logic           tx_valid_i,
    output logic           tx_ready_o,
    output logic [7:0]     rx_data_o,
    output logic           rx_valid_o,
    output logic           abort_o,
    output logic           hold_o,
    output logic           drive_o,
    output logic           det_en_o,
    output logic           locked_o,
    output logic [P_W-1:0] period_o
);

    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_SYNC_CLKS);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(8 << P_W);

    typedef struct packed {
        dwp_state_e           st;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_BITS-1:0] sh;
        logic [7:0]           rxd;
        logic [P_W-1:0]       per;
        logic                 locked;
        logic                 hold;
        logic                 drive;
        logic                 abort;
        logic                 rxv;
    } eng_s;

    eng_s q, d;
    logic [CNT_W-1:0] reload;
    logic             det_en;
    logic             ready;

    function automatic eng_s to_echo(eng_s s, logic [CNT_W-1:0] rl);
        eng_s r;
        r        = s;
        r.st     = ST_ECHO;
        r.cnt    = rl;
        r.idx    = '0;
        r.drive  = 1'b1;
        r.locked = 1'b0;
        r.abort  = 1'b1;
        return r;
    endfunction

    always_comb begin
        reload = {{(CNT_W-P_W){1'b0}}, q.per} - CNT_W'(1);
        det_en = (q.st == ST_UNLOCK) || (q.st == ST_MEASURE) ||
                 (q.st == ST_IDLE)   || (q.st == ST_RX);
        ready  = (q.st == ST_IDLE) && line_i;

        d       = q;
        d.abort = 1'b0;
        d.rxv   = 1'b0;

        if (brk_i && det_en) begin
            d.hold = 1'b1;
            if (q.locked) begin
                d = to_echo(d, reload);
            end else begin
                d.abort = 1'b1;
                d.st    = ST_RELEASE;
                d.drive = 1'b0;
            end
        end else begin
            case (q.st)
                ST_UNLOCK: begin
                    if (fall_i) begin
                        d.st  = ST_MEASURE;
                        d.cnt = CNT_W'(1);
                    end
                end
                ST_MEASURE: begin
                    if (line_i) begin
                        if (q.cnt < MIN_C || q.cnt >= MAX_C) begin
                            d.abort = 1'b1;
                            d.st    = ST_UNLOCK;
                        end else begin
                            d.per    = q.cnt[P_W+SYNC_SHIFT-1:SYNC_SHIFT];
                            d.locked = 1'b1;
                            d.st     = ST_IDLE;
                        end
                    end else if (q.cnt != '1) begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_IDLE: begin
                    if (fall_i) begin
                        d.st  = ST_RX;
                        d.cnt = {{(CNT_W-P_W){1'b0}}, q.per} >> 1;
                        d.idx = '0;
                    end else if (tx_valid_i && ready) begin
                        d.st    = ST_TX;
                        d.sh    = {1'b1, tx_data_i, 1'b0};
                        d.drive = 1'b1;
                        d.cnt   = reload;
                        d.idx   = '0;
                    end
                end
                ST_RX: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end else if (q.idx == '0) begin
                        if (line_i) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.idx = q.idx + IDX_W'(1);
                            d.cnt = reload;
                        end
                    end else if (q.idx == IDX_W'(FRAME_BITS-1)) begin
                        if (!line_i) begin
                            d = to_echo(d, reload);
                        end else begin
                            d.rxv = 1'b1;
                            d.st  = ST_IDLE;
                        end
                    end else begin
                        d.rxd = {line_i, q.rxd[7:1]};
                        d.idx = q.idx + IDX_W'(1);
                        d.cnt = reload;
                    end
                end
                ST_TX: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end else if (!q.drive && !line_i) begin
                        d = to_echo(d, reload);
                    end else if (q.idx == IDX_W'(FRAME_BITS-1)) begin
                        d.st    = ST_IDLE;
                        d.drive = 1'b0;
                    end else begin
                        d.sh    = {1'b1, q.sh[FRAME_BITS-1:1]};
                        d.drive = ~q.sh[1];
                        d.idx   = q.idx + IDX_W'(1);
                        d.cnt   = reload;
                    end
                end
                ST_ECHO: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end else if (q.idx == IDX_W'(ECHO_BITS-1)) begin
                        d.st    = ST_RELEASE;
                        d.drive = 1'b0;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                        d.cnt = reload;
                    end
                end
                ST_RELEASE: begin
                    if (line_i) begin
                        d.st   = ST_UNLOCK;
                        d.hold = 1'b0;
                    end
                end
                default: d.st = ST_UNLOCK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_UNLOCK;
        end else begin
            q <= d;
        end
    end

    assign tx_ready_o = ready;
    assign rx_data_o  = q.rxd;
    assign rx_valid_o = q.rxv;
    assign abort_o    = q.abort;
    assign hold_o     = q.hold;
    assign drive_o    = q.drive;
    assign det_en_o   = det_en;
    assign locked_o   = q.locked;
    assign period_o   = q.per;

endmodule

// File: rtl/dbg_wire_port.sv
module dbg_wire_port #(
    parameter int P_W         = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_i,
    output logic       pull_low_o,
    output logic [7:0] rx_data_o,
    output logic       rx_valid_o,
    input  logic [7:0] tx_data_i,
    input  logic       tx_valid_i,
    output logic       tx_ready_o,
    output logic       abort_o,
    output logic       hold_rst_o
);

    localparam int CNT_W     = P_W + 4;
    localparam int UNLK_CLKS = dwp_pkg::BREAK_BITS << P_W;

    logic           line;
    logic           fall;
    logic           brk;
    logic           det_en;
    logic           locked;
    logic [P_W-1:0] period;

    dwp_line_in #(.STAGES(SYNC_STAGES)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_i),
        .line_o (line),
        .fall_o (fall)
    );

    dwp_brk_det #(.P_W(P_W), .CNT_W(CNT_W), .UNLK_CLKS(UNLK_CLKS)) u_brk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (det_en),
        .line_i   (line),
        .locked_i (locked),
        .period_i (period),
        .brk_o    (brk)
    );

    dwp_engine #(.P_W(P_W), .CNT_W(CNT_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line),
        .fall_i     (fall),
        .brk_i      (brk),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .tx_ready_o (tx_ready_o),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .abort_o    (abort_o),
        .hold_o     (hold_rst_o),
        .drive_o    (pull_low_o),
        .det_en_o   (det_en),
        .locked_o   (locked),
        .period_o   (period)
    );

endmodule

// File: rtl/dwp_checker.sv
module dwp_checker (
    input logic clk,
    input logic rst_n,
    input logic pull_low,
    input logic rx_valid,
    input logic tx_ready,
    input logic abort,
    input logic hold
);

    p_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_ready_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !pull_low);

    p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

    p_hold_with_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> abort);

    p_hold_blocks_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !tx_ready);

    p_abort_unlocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !tx_ready);

endmodule

bind dbg_wire_port dwp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pull_low (pull_low_o),
    .rx_valid (rx_valid_o),
    .tx_ready (tx_ready_o),
    .abort    (abort_o),
    .hold     (hold_rst_o)
);

// File: tb/tb_dbg_wire_port.sv
module tb_dbg_wire_port;

    localparam int PW = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       pull_low, rx_valid, tx_ready, abort, hold;
    logic [7:0] rx_data;
    wire        pad = ~(host_low | pull_low);

    int n_chk = 0, n_fail = 0;
    int rx_cnt = 0, ab_cnt = 0, rises = 0, run = 0, last_run = 0;
    logic [7:0] rx_last = 8'h00;
    logic pl_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbg_wire_port #(.P_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .pad_i(pad), .pull_low_o(pull_low),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .tx_data_i(tx_data),
        .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .abort_o(abort),
        .hold_rst_o(hold)
    );

    always @(negedge clk) begin
        if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
        if (abort) ab_cnt++;
        if (pull_low) begin
            if (!pl_prev) rises++;
            run++;
        end else if (pl_prev) begin
            last_run = run;
            run = 0;
        end
        pl_prev = pull_low;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_char(input logic [7:0] dv, input int p, input bit stop_hi);
        host_low = 1'b1; idle(p);
        for (int i = 0; i < 8; i++) begin host_low = ~dv[i]; idle(p); end
        host_low = ~stop_hi; idle(p);
        host_low = 1'b0;
    endtask

    task automatic do_sync(input int p);
        host_char(8'h80, p, 1'b1);
        idle(2 * p);
        chk(tx_ready === 1'b1, "R2 locked after sync", int'(tx_ready), 1);
    endtask

    task automatic rx_one(input logic [7:0] dv, input int p);
        int c0 = rx_cnt;
        host_char(dv, p, 1'b1);
        idle(2 * p + 4);
        chk(rx_cnt == c0 + 1 && rx_last == dv, "R4 received byte", int'(rx_last), int'(dv));
    endtask

    task automatic start_tx(input logic [7:0] dv);
        int g = 0;
        while (!tx_ready && g < 2000) begin idle(1); g++; end
        tx_data = dv; tx_valid = 1'b1;
        idle(1);
        tx_valid = 1'b0;
        g = 0;
        while (!pull_low && g < 100) begin idle(1); g++; end
    endtask

    task automatic tx_one(input logic [7:0] dv, input int p);
        logic [9:0] got;
        start_tx(dv);
        idle(p / 2);
        got[0] = pull_low;
        for (int i = 1; i < 10; i++) begin idle(p); got[i] = pull_low; end
        chk(got == {1'b0, ~dv, 1'b1}, "R5 transmitted frame", int'(got), int'({1'b0, ~dv, 1'b1}));
        idle(p + 4);
    endtask

    task automatic host_break_locked(input int p);
        int a0 = ab_cnt;
        host_low = 1'b1;
        idle(11 * p);
        chk(hold === 1'b1, "R8 hold during break", int'(hold), 1);
        chk(ab_cnt == a0 + 1, "R8 abort on break", ab_cnt, a0 + 1);
        idle(p);
        host_low = 1'b0;
        idle(20 * p);
        chk(hold === 1'b1, "R8 hold while echo keeps line low", int'(hold), 1);
        idle(30 * p);
        chk(hold === 1'b0, "R8 hold released on high line", int'(hold), 0);
        chk(last_run == 40 * p, "R9 echo length", last_run, 40 * p);
        chk(tx_ready === 1'b0, "R10 unlocked after break", int'(tx_ready), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int a0, r0, c0;
        idle(5);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        chk(pull_low === 1'b0, "R1 pull_low", int'(pull_low), 0);
        chk(tx_ready === 1'b0, "R1 tx_ready", int'(tx_ready), 0);
        chk(hold === 1'b0 && rx_valid === 1'b0, "R1 hold/rx_valid", int'(hold), 0);
        chk(ab_cnt == 0, "R1 abort", ab_cnt, 0);

        // R12 transmit request ignored while unlocked
        r0 = rises;
        tx_data = 8'h00; tx_valid = 1'b1; idle(50); tx_valid = 1'b0;
        chk(rises == r0, "R12 no pull while unlocked", rises, r0);
        chk(tx_ready === 1'b0, "R12 not ready", int'(tx_ready), 0);

        // R3 sync with period 3 rejected
        a0 = ab_cnt; r0 = rises;
        host_char(8'h80, 3, 1'b1);
        idle(10);
        chk(ab_cnt == a0 + 1, "R3 abort on short sync", ab_cnt, a0 + 1);
        chk(tx_ready === 1'b0, "R3 still unlocked", int'(tx_ready), 0);
        chk(rises == r0, "R3 no echo", rises, r0);

        // R11 unlocked break: 600 low clocks > 576
        a0 = ab_cnt;
        host_low = 1'b1; idle(600);
        chk(hold === 1'b1, "R11 hold while low", int'(hold), 1);
        host_low = 1'b0; idle(10);
        chk(hold === 1'b0, "R11 hold cleared", int'(hold), 0);
        chk(ab_cnt == a0 + 1, "R11 abort", ab_cnt, a0 + 1);
        chk(rises == r0, "R11 no echo", rises, r0);

        // Sweep of learned periods
        for (int p = 4; p <= 12; p++) begin
            do_sync(p);
            for (int k = 0; k < 6; k++) rx_one(8'((k * 37 + p * 11) & 255), p);
            for (int k = 0; k < 3; k++) tx_one(8'((k * 91 + p * 5 + 3) & 255), p);
            a0 = ab_cnt;
            rx_one(8'h00, p);
            chk(ab_cnt == a0, "R8 nine-period low is a character", ab_cnt, a0);
            host_break_locked(p);
        end

        // Exhaustive byte sweep at period 8
        do_sync(8);
        for (int v = 0; v < 256; v++) rx_one(8'(v), 8);
        for (int v = 0; v < 256; v++) tx_one(8'(v), 8);

        // R6 framing error
        a0 = ab_cnt; c0 = rx_cnt;
        host_char(8'h5A, 8, 1'b0);
        idle(400);
        chk(ab_cnt == a0 + 1, "R6 abort on framing", ab_cnt, a0 + 1);
        chk(rx_cnt == c0, "R6 no byte delivered", rx_cnt, c0);
        chk(hold === 1'b0, "R6 no hold", int'(hold), 0);
        chk(last_run == 320, "R9 echo after framing", last_run, 320);
        chk(tx_ready === 1'b0, "R10 unlocked after framing", int'(tx_ready), 0);

        // R7 collision during transmit
        do_sync(8);
        a0 = ab_cnt;
        start_tx(8'hFF);
        idle(24);
        host_low = 1'b1; idle(8); host_low = 1'b0;
        idle(360);
        chk(ab_cnt == a0 + 1, "R7 abort on collision", ab_cnt, a0 + 1);
        chk(last_run == 320, "R9 echo after collision", last_run, 320);
        chk(hold === 1'b0, "R7 no hold", int'(hold), 0);
        chk(tx_ready === 1'b0, "R10 unlocked after collision", int'(tx_ready), 0);

        // R10 new rate learned afresh
        do_sync(5);
        rx_one(8'hC3, 5);
        tx_one(8'h3C, 5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule